// File: doc/BRIEF.md
# Two-Cell Pack Protection Controller

This block is the digital decision core of a protector for a battery pack built from two lithium-ion cells in series. Analog comparators elsewhere reduce the cell voltages and sense-resistor drops to single-bit condition flags: some cell is above the overvoltage limit, every cell is below the charge re-enable limit, some cell is below the undervoltage limit, discharge overcurrent, charger present, and a cell input is floating. A pack-disable input lets an outside agent switch the pack off. The block turns these flags into two switch controls: a charge-enable output with a high-impedance off state and a push-pull discharge-enable output.

Every fault must persist before it acts. Three persistence timers count pulses on a slow `tick` input. Each timer restarts from zero whenever its flag drops. Once it has expired, it does not fire again until its flag has dropped. An expired overvoltage timer sets an overcharge latch, which is released only when all cells fall below the re-enable level. That level sits 150 mV under the overvoltage limit, which gives the latch its hysteresis. An expired undervoltage timer puts the block into sleep, and only a charger being present wakes it. An expired overcurrent timer pulls the discharge output low for as long as overcurrent stays flagged. At tick periods of 1 ms the default loads give about 950 ms for overvoltage and undervoltage and 12 ms for overcurrent.

Top module: `pack_guard_top`

## Requirements
- R1: After the synchronous active-high reset, `asleep` is 1, `dsg_on` is 0, and the charge output drives high (`chg_oe`=1, `chg_drv`=1).
- R2: When the overvoltage flag has stayed high through OV_TICKS tick pulses, `chg_oe` is 0 from the clock edge that samples the last of those ticks.
- R3: If the overvoltage flag drops before OV_TICKS ticks have been counted, the charge output does not change. A later episode must again persist for the full OV_TICKS ticks.
- R4: Once cut off by overvoltage, the charge output stays off, even after the overvoltage flag has dropped, until `cells_below_ce` is seen high. From the next edge it is on again.
- R5: A high `cell_float` counts as overvoltage. When it persists for OV_TICKS ticks, the charge output turns off.
- R6: When the undervoltage flag has stayed high through UV_TICKS ticks, `dsg_on` goes to 0 and `asleep` goes to 1 at the edge that samples the last tick.
- R7: While asleep, `dsg_on` stays 0 and only a high `chg_detect` clears `asleep`. From the following edge `dsg_on` is 1, provided no other cause holds it low.
- R8: When overcurrent has stayed high through OC_TICKS ticks, `dsg_on` is 0 from that edge. It returns to 1 in the same cycle that `over_cur` drops.
- R9: While `pack_off` is 1, `chg_oe` and `dsg_on` are both 0 and the overcurrent timer is held cleared. After `pack_off` falls, overcurrent needs a full OC_TICKS ticks before it acts.
- R10: When undervoltage and overcurrent are both pending, whichever timer expires first drives `dsg_on` low. Only the undervoltage expiry sets `asleep`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Delay time-base pulse, one clock wide |
| cell_ov | input | 1 | Some cell is above the overvoltage limit |
| cells_below_ce | input | 1 | Every cell is below the charge re-enable limit |
| cell_uv | input | 1 | Some cell is below the undervoltage limit |
| over_cur | input | 1 | Discharge overcurrent detected |
| chg_detect | input | 1 | Charger present |
| cell_float | input | 1 | A cell input is floating |
| pack_off | input | 1 | External pack disable |
| chg_oe | output | 1 | Charge output driver enable (0 = high impedance) |
| chg_drv | output | 1 | Level driven on the charge output when enabled |
| dsg_on | output | 1 | Discharge switch enable |
| asleep | output | 1 | Low-power sleep state |

## Verification
The directed patterns hold each fault for exactly one tick fewer than its delay and then for exactly its delay. This separates an off-by-one count from correct persistence. Dropping a flag one tick early and raising it again shows whether the counter truly restarts. Overlapping undervoltage with a shorter overcurrent, and asserting `pack_off` during overcurrent, show whether each path forces the outputs only by its own rule. Long runs of randomly toggled, sticky flags with sparse ticks are then compared cycle by cycle against a countdown model in the bench.

// File: rtl/pack_guard_pkg.sv
package pack_guard_pkg;

  // Counter width able to hold 0..delay.
  function automatic int unsigned cnt_bits(input int unsigned delay);
    return (delay < 2) ? 1 : $clog2(delay + 1);
  endfunction

  // Discharge path power state.
  typedef enum logic {PS_AWAKE = 1'b0, PS_SLEEP = 1'b1} pwr_state_t;

  // Final decision for the discharge switch.
  function automatic logic dsg_allowed(input logic sleeping, input logic disabled,
                                       input logic oc_tripped, input logic oc_now);
    return !sleeping && !disabled && !(oc_tripped && oc_now);
  endfunction

endpackage

// File: rtl/fault_timer.sv
module fault_timer #(
  parameter int unsigned DELAY = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic flag,
  input  logic hold,
  output logic fire,
  output logic done
);
  localparam int unsigned CW = pack_guard_pkg::cnt_bits(DELAY);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  // One-cycle expiry pulse on the tick that completes the delay.
  assign fire = flag && !hold && tick && !done_q && (cnt_q == LAST);
  assign done = done_q;

  always_ff @(posedge clk) begin
    if (rst || !flag || hold) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (fire) begin
      done_q <= 1'b1;
    end else if (tick && !done_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/charge_path.sv
module charge_path #(
  parameter int unsigned OV_TICKS = 950
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cell_ov,
  input  logic cell_float,
  input  logic cells_below_ce,
  output logic ov_fire,
  output logic ovc_q
);
  logic ov_flag;
  logic ov_done;

  // A floating input is handled exactly as an overvoltage.
  assign ov_flag = cell_ov || cell_float;

  fault_timer #(.DELAY(OV_TICKS)) u_ov_tmr (
    .clk (clk),
    .rst (rst),
    .tick(tick),
    .flag(ov_flag),
    .hold(1'b0),
    .fire(ov_fire),
    .done(ov_done)
  );

  always_ff @(posedge clk) begin
    if (rst)                 ovc_q <= 1'b0;
    else if (ov_fire)        ovc_q <= 1'b1;
    else if (cells_below_ce) ovc_q <= 1'b0;
  end
endmodule

// File: rtl/discharge_path.sv
module discharge_path #(
  parameter int unsigned UV_TICKS = 950,
  parameter int unsigned OC_TICKS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cell_uv,
  input  logic over_cur,
  input  logic chg_detect,
  input  logic pack_off,
  output logic uv_fire,
  output logic oc_fire,
  output logic oc_trip,
  output logic sleeping
);
  import pack_guard_pkg::*;

  logic       uv_done;
  logic       oc_done;
  pwr_state_t pwr_q;

  fault_timer #(.DELAY(UV_TICKS)) u_uv_tmr (
    .clk (clk),
    .rst (rst),
    .tick(tick),
    .flag(cell_uv),
    .hold(1'b0),
    .fire(uv_fire),
    .done(uv_done)
  );

  // The disable input holds the overcurrent timer cleared.
  fault_timer #(.DELAY(OC_TICKS)) u_oc_tmr (
    .clk (clk),
    .rst (rst),
    .tick(tick),
    .flag(over_cur),
    .hold(pack_off),
    .fire(oc_fire),
    .done(oc_done)
  );

  assign oc_trip  = oc_done;
  assign sleeping = (pwr_q == PS_SLEEP);

  always_ff @(posedge clk) begin
    if (rst)             pwr_q <= PS_SLEEP;
    else if (uv_fire)    pwr_q <= PS_SLEEP;
    else if (chg_detect) pwr_q <= PS_AWAKE;
  end
endmodule

// File: rtl/pack_guard_top.sv
module pack_guard_top #(
  parameter int unsigned OV_TICKS = 950,
  parameter int unsigned UV_TICKS = 950,
  parameter int unsigned OC_TICKS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cell_ov,
  input  logic cells_below_ce,
  input  logic cell_uv,
  input  logic over_cur,
  input  logic chg_detect,
  input  logic cell_float,
  input  logic pack_off,
  output logic chg_oe,
  output logic chg_drv,
  output logic dsg_on,
  output logic asleep
);
  import pack_guard_pkg::*;

  logic ov_fire;
  logic ovc_q;
  logic uv_fire;
  logic oc_fire;
  logic oc_trip;
  logic sleeping;

  charge_path #(.OV_TICKS(OV_TICKS)) u_chg (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .cell_ov       (cell_ov),
    .cell_float    (cell_float),
    .cells_below_ce(cells_below_ce),
    .ov_fire       (ov_fire),
    .ovc_q         (ovc_q)
  );

  discharge_path #(.UV_TICKS(UV_TICKS), .OC_TICKS(OC_TICKS)) u_dsg (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cell_uv   (cell_uv),
    .over_cur  (over_cur),
    .chg_detect(chg_detect),
    .pack_off  (pack_off),
    .uv_fire   (uv_fire),
    .oc_fire   (oc_fire),
    .oc_trip   (oc_trip),
    .sleeping  (sleeping)
  );

  assign chg_oe  = !ovc_q && !pack_off;
  assign chg_drv = chg_oe;
  assign dsg_on  = dsg_allowed(sleeping, pack_off, oc_trip, over_cur);
  assign asleep  = sleeping;
endmodule

// File: rtl/pack_guard_chk.sv
module pack_guard_chk (
  input logic clk,
  input logic rst,
  input logic cells_below_ce,
  input logic over_cur,
  input logic chg_detect,
  input logic pack_off,
  input logic chg_oe,
  input logic dsg_on,
  input logic asleep,
  input logic ov_fire,
  input logic ovc_q,
  input logic uv_fire,
  input logic oc_fire
);
  AST_RESET_SLEEP: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> asleep && !dsg_on); // R1
  AST_OV_CUTS_CHG: assert property (@(posedge clk) disable iff (rst) ov_fire |=> !chg_oe); // R2
  AST_OVC_HOLDS: assert property (@(posedge clk) disable iff (rst) ovc_q && !cells_below_ce |=> ovc_q); // R4
  AST_UV_SLEEPS: assert property (@(posedge clk) disable iff (rst) uv_fire |=> asleep && !dsg_on); // R6
  AST_SLEEP_STICKY: assert property (@(posedge clk) disable iff (rst) asleep && !chg_detect && !uv_fire |=> asleep); // R7
  AST_OC_CUTS_DSG: assert property (@(posedge clk) disable iff (rst) oc_fire ##1 over_cur |-> !dsg_on); // R8
  AST_OFF_GATES: assert property (@(posedge clk) disable iff (rst) pack_off |-> !chg_oe && !dsg_on); // R9
  AST_OFF_HOLDS_OC: assert property (@(posedge clk) disable iff (rst) pack_off |-> !oc_fire); // R9
  AST_OC_NO_SLEEP: assert property (@(posedge clk) disable iff (rst) oc_fire && !uv_fire && !asleep && !chg_detect |=> !asleep); // R10
endmodule

bind pack_guard_top pack_guard_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .cells_below_ce(cells_below_ce),
  .over_cur      (over_cur),
  .chg_detect    (chg_detect),
  .pack_off      (pack_off),
  .chg_oe        (chg_oe),
  .dsg_on        (dsg_on),
  .asleep        (asleep),
  .ov_fire       (ov_fire),
  .ovc_q         (ovc_q),
  .uv_fire       (uv_fire),
  .oc_fire       (oc_fire)
);

// File: tb/tb_pack_guard_top.sv
module tb_pack_guard_top;
  localparam int unsigned OVT = 20;
  localparam int unsigned UVT = 15;
  localparam int unsigned OCT = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 0, cell_ov = 0, cells_below_ce = 0, cell_uv = 0;
  logic over_cur = 0, chg_detect = 0, cell_float = 0, pack_off = 0;
  logic chg_oe, chg_drv, dsg_on, asleep;

  int tests = 0;
  int fails = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  pack_guard_top #(.OV_TICKS(OVT), .UV_TICKS(UVT), .OC_TICKS(OCT)) dut (
    .clk(clk), .rst(rst), .tick(tick), .cell_ov(cell_ov),
    .cells_below_ce(cells_below_ce), .cell_uv(cell_uv), .over_cur(over_cur),
    .chg_detect(chg_detect), .cell_float(cell_float), .pack_off(pack_off),
    .chg_oe(chg_oe), .chg_drv(chg_drv), .dsg_on(dsg_on), .asleep(asleep)
  );

  // Countdown reference: remaining ticks until each fault acts.
  int unsigned ov_left, uv_left, oc_left;
  bit ov_hit, uv_hit, oc_hit, m_ovc, m_sleep;

  function automatic bit exp_chg();
    return !m_ovc && !pack_off;
  endfunction

  function automatic bit exp_dsg();
    return !m_sleep && !pack_off && !(oc_hit && over_cur);
  endfunction

  task automatic model_reset();
    ov_left = OVT; uv_left = UVT; oc_left = OCT;
    ov_hit = 0; uv_hit = 0; oc_hit = 0; m_ovc = 0; m_sleep = 1;
  endtask

  task automatic model_edge();
    bit ovf, uvf, ocf;
    bit ovflag;
    ovflag = cell_ov || cell_float;
    ovf = ovflag && tick && !ov_hit && ov_left == 1;
    uvf = cell_uv && tick && !uv_hit && uv_left == 1;
    ocf = over_cur && !pack_off && tick && !oc_hit && oc_left == 1;
    if (!ovflag) begin ov_left = OVT; ov_hit = 0; end
    else if (ovf) ov_hit = 1;
    else if (tick && !ov_hit) ov_left--;
    if (!cell_uv) begin uv_left = UVT; uv_hit = 0; end
    else if (uvf) uv_hit = 1;
    else if (tick && !uv_hit) uv_left--;
    if (!over_cur || pack_off) begin oc_left = OCT; oc_hit = 0; end
    else if (ocf) oc_hit = 1;
    else if (tick && !oc_hit) oc_left--;
    if (ovf) m_ovc = 1; else if (cells_below_ce) m_ovc = 0;
    if (uvf) m_sleep = 1; else if (chg_detect) m_sleep = 0;
  endtask

  task automatic check(input string tag, input string what, input bit act, input bit exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "chg_oe", chg_oe, exp_chg());
    check(tag, "chg_drv", chg_drv, exp_chg());
    check(tag, "dsg_on", dsg_on, exp_dsg());
    check(tag, "asleep", asleep, m_sleep);
  endtask

  // One clock: inputs already set at a falling edge; sample at the next one.
  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h5eed_2c11;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1", "asleep", asleep, 1'b1);
    check("R1", "dsg_on", dsg_on, 1'b0);
    check("R1", "chg_oe", chg_oe, 1'b1);
    check("R1", "chg_drv", chg_drv, 1'b1);

    // R7: charger wakes the block
    chg_detect = 1; step("R7"); chg_detect = 0; step("R7");
    check("R7", "dsg_on after wake", dsg_on, 1'b1);

    // R2: exactly OVT ticks
    tick = 1; cell_ov = 1;
    run("R2", OVT - 1);
    check("R2", "chg_oe one tick early", chg_oe, 1'b1);
    step("R2");
    check("R2", "chg_oe at expiry", chg_oe, 1'b0);
    // R4: stays off after OV drops until re-enable level seen
    cell_ov = 0; run("R4", 5);
    check("R4", "chg_oe latched", chg_oe, 1'b0);
    cells_below_ce = 1; step("R4"); cells_below_ce = 0; step("R4");
    check("R4", "chg_oe released", chg_oe, 1'b1);

    // R3: early drop restarts the count
    cell_ov = 1; run("R3", OVT - 1);
    cell_ov = 0; step("R3");
    cell_ov = 1; run("R3", OVT - 1);
    check("R3", "chg_oe after restart", chg_oe, 1'b1);
    cell_ov = 0; step("R3");

    // R5: floating input acts as overvoltage
    cell_float = 1; run("R5", OVT);
    check("R5", "chg_oe float", chg_oe, 1'b0);
    cell_float = 0; cells_below_ce = 1; step("R5"); cells_below_ce = 0; step("R5");

    // R8: overcurrent trip and instant release
    over_cur = 1; run("R8", OCT - 1);
    check("R8", "dsg_on early", dsg_on, 1'b1);
    step("R8");
    check("R8", "dsg_on tripped", dsg_on, 1'b0);
    run("R8", 3);
    over_cur = 0; #1;
    check("R8", "dsg_on release", dsg_on, 1'b1);
    step("R8");

    // R9: disable gates outputs and holds the overcurrent timer
    pack_off = 1; over_cur = 1; #1;
    check("R9", "chg_oe off", chg_oe, 1'b0);
    check("R9", "dsg_on off", dsg_on, 1'b0);
    run("R9", OCT * 3);
    pack_off = 0; #1;
    check("R9", "dsg_on resumes", dsg_on, 1'b1);
    run("R9", OCT - 1);
    check("R9", "oc full delay", dsg_on, 1'b1);
    step("R9");
    check("R9", "oc trip after", dsg_on, 1'b0);
    over_cur = 0; step("R9");

    // R10: overcurrent expires first, no sleep; then undervoltage sleeps
    cell_uv = 1; over_cur = 1; run("R10", OCT);
    check("R10", "dsg_on oc first", dsg_on, 1'b0);
    check("R10", "asleep oc only", asleep, 1'b0);
    run("R10", UVT - OCT);
    check("R10", "asleep uv", asleep, 1'b1);
    over_cur = 0; step("R10");
    check("R10", "dsg_on stays low", dsg_on, 1'b0);

    // R6: undervoltage alone after wake
    cell_uv = 0; chg_detect = 1; step("R6"); chg_detect = 0; step("R6");
    cell_uv = 1; run("R6", UVT - 1);
    check("R6", "asleep early", asleep, 1'b0);
    step("R6");
    check("R6", "asleep", asleep, 1'b1);
    check("R6", "dsg_on", dsg_on, 1'b0);
    cell_uv = 0; run("R7", 4);
    check("R7", "still asleep", asleep, 1'b1);

    // Random sticky flags with sparse ticks
    for (int i = 0; i < 20000; i++) begin
      tick = ($urandom % 3) == 0;
      if (($urandom % 40) == 0) cell_ov = ~cell_ov;
      if (($urandom % 30) == 0) cells_below_ce = ~cells_below_ce;
      if (($urandom % 40) == 0) cell_uv = ~cell_uv;
      if (($urandom % 25) == 0) over_cur = ~over_cur;
      if (($urandom % 20) == 0) chg_detect = ~chg_detect;
      if (($urandom % 90) == 0) cell_float = ~cell_float;
      if (($urandom % 60) == 0) pack_off = ~pack_off;
      step("R4/R8");
    end

    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule